// File: doc/BRIEF.md
# Programmable Interval Clock

This block is a memory-mapped real-time clock. A 16-bit counter steps up or down once per tick of a chosen rate source. When a step leaves the counter at zero, the block records a terminal-count event in its status flags and, if enabled, holds an interrupt request. It then either reloads the counter from a count-set buffer and carries on, or stops itself.

Software reaches three word registers over a simple register bus:

- a control/status register (CSR),
- the count-set buffer,
- the counter.

The bus has an address, write data, a combinational read-data return, and single-cycle read, write and byte strobes. Four tick-enable inputs, each one clock wide, carry the rate pulses: a fast crystal, a slow crystal, the line frequency and an external trigger. Bus arbitration, vector delivery and tick generation live outside the block.

Software sets the start count by writing the buffer and starts counting with a CSR write that sets run. It services an event by reading the CSR, which returns the flags and then clears them. A maintenance bit lets software single-step the counter while it is stopped.

Top module: `prog_interval_clock`

## Requirements
- R1: After reset the CSR, buffer and counter all read zero and `irq` is low.
- R2: Only word accesses at an even address are decoded. Offset 0 is the CSR, offset 2 is the buffer and offset 4 is the counter; offset 6 decodes but does nothing. A CSR read returns bits 15 and 7:0 of its state, with bits 14:8 and bit 5 always zero. The buffer offset always reads zero. The counter offset returns the count.
- R3: A CSR write stores bits 0 (run), 2:1 (rate), 3 (repeat), 4 (count up) and 6 (interrupt enable). It clears done (bit 7) and overrun (bit 15) and drops `irq`.
- R4: A buffer write loads the value into both the buffer and the counter, clears done and overrun, and drops `irq`.
- R5: A write to the counter offset, a write with the byte strobe set, and any access at an odd address leave every register and `irq` unchanged. Reads of this kind return zero.
- R6: While run is set, the counter takes a tick only when the tick input selected by rate is high. The rate code picks the input: 0 is the fast crystal, 1 the slow crystal, 2 the line frequency, 3 the external trigger (`rateTick` bit index equals the code). With run clear, no tick input moves the counter.
- R7: A tick adds one when bit 4 is set and subtracts one when it is clear, wrapping modulo 2^16.
- R8: A tick that leaves the counter at zero sets overrun if done is already set, and sets done otherwise. If interrupt enable is set, it also raises `irq`, a level that stays high until a CSR read, a CSR write or a buffer write.
- R9: At a terminal count in repeat mode the counter reloads from the buffer. In single mode the buffer is cleared, run is cleared and the counter stays at zero.
- R10: A CSR read clears done, overrun and `irq` at the clock edge that ends the access. The read returns the flags as they were before that edge. If a terminal count falls in the same cycle, it is recorded against the cleared flags.
- R11: A CSR write with bit 0 clear and bit 5 set applies exactly one tick at once. The tick uses the direction, mode and interrupt-enable bits just written. Bit 5 is never stored.
- R12: A CSR write or a buffer write in the same cycle as a selected tick wins, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Byte offset of the access |
| busWdata | input | 16 | Write data |
| busRd | input | 1 | Read strobe, one cycle |
| busWr | input | 1 | Write strobe, one cycle |
| busByte | input | 1 | Byte access marker; such accesses are ignored |
| busRdata | output | 16 | Read data, valid in the cycle busRd is high |
| rateTick | input | 4 | One-cycle tick pulses, index = rate code |
| irq | output | 1 | Interrupt request level |

## Verification
Counting is tried in both directions across the 0xFFFF/0x0000 wrap. It is also tried with start values of one and two, so a terminal count comes after a single step or after two. Single mode and repeat mode are each driven into a second terminal count, which separates done from overrun. Random tick patterns on all four inputs, under every rate code, show whether unselected sources leak into the count. Random mixes of reads, writes, byte accesses and odd addresses, landing in the same cycle as ticks, cover the same-cycle precedence between bus side effects and terminal counts.

// File: rtl/pic_pkg.sv
package pic_pkg;

  // CSR bit positions; software decodes these, so they are fixed
  localparam int BIT_RUN    = 0;
  localparam int BIT_RATE_L = 1;
  localparam int BIT_RATE_H = 2;
  localparam int BIT_REP    = 3;
  localparam int BIT_UP     = 4;
  localparam int BIT_STEP   = 5;
  localparam int BIT_IE     = 6;
  localparam int BIT_DONE   = 7;
  localparam int BIT_OVF    = 15;
  localparam int CSR_W      = 16;
  localparam int RATE_W     = BIT_RATE_H - BIT_RATE_L + 1;

  // word slots in the register window
  typedef enum logic [1:0] {
    SLOT_CSR = 2'd0,
    SLOT_BUF = 2'd1,
    SLOT_CTR = 2'd2,
    SLOT_NIL = 2'd3
  } picSlot_e;

  typedef struct packed {
    logic        ovf;
    logic        done;
    logic        ie;
    logic        up;
    logic        rep;
    logic [RATE_W-1:0] rate;
    logic        run;
  } picCtl_t;

  // control -> datapath strobes
  typedef struct packed {
    logic     csrWr;
    logic     bufWr;
    logic     csrRd;
    logic     rdEn;
    picSlot_e rdSel;
    logic     autoTick;
    logic     manualTick;
  } picStrobes_t;

endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NUM_SRC = 4
) (
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busRd,
  input  logic               busWr,
  input  logic               busByte,
  input  logic               wdRun,
  input  logic               wdStep,
  input  logic [NUM_SRC-1:0] rateTick,
  input  logic               csrRun,
  input  logic [RATE_W-1:0]  csrRate,
  output picStrobes_t        stb
);

  logic wordOk;
  picSlot_e slot;
  logic [NUM_SRC-1:0] srcHit;
  logic selTick;

  assign wordOk = !busByte && !busAddr[0];
  assign slot   = picSlot_e'(busAddr[2:1]);

  // per-source match against the rate code
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign srcHit[g] = rateTick[g] && (csrRate == RATE_W'(g));
  end
  assign selTick = |srcHit;

  always_comb begin
    stb            = '0;
    stb.rdEn       = wordOk && busRd;
    stb.rdSel      = slot;
    stb.csrRd      = wordOk && busRd && (slot == SLOT_CSR);
    stb.csrWr      = wordOk && busWr && (slot == SLOT_CSR);
    stb.bufWr      = wordOk && busWr && (slot == SLOT_BUF);
    stb.manualTick = stb.csrWr && !wdRun && wdStep;
    stb.autoTick   = csrRun && selTick && !stb.csrWr && !stb.bufWr;
  end

endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  picStrobes_t       stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              csrRun,
  output logic [RATE_W-1:0] csrRate,
  output logic              csrDone,
  output logic              csrOvf,
  output logic [DATA_W-1:0] ctrQ,
  output logic [DATA_W-1:0] bufQ,
  output logic              irq
);

  picCtl_t ctlQ, ctlN;
  logic [DATA_W-1:0] ctrN, bufN, stepped;
  logic irqQ, irqN, tickNow;
  logic [CSR_W-1:0] csrView;

  always_comb begin
    ctlN = ctlQ;
    ctrN = ctrQ;
    bufN = bufQ;
    irqN = irqQ;
    tickNow = stb.autoTick || stb.manualTick;

    if (stb.csrWr) begin
      ctlN.run  = wdata[BIT_RUN];
      ctlN.rate = wdata[BIT_RATE_H:BIT_RATE_L];
      ctlN.rep  = wdata[BIT_REP];
      ctlN.up   = wdata[BIT_UP];
      ctlN.ie   = wdata[BIT_IE];
      ctlN.done = 1'b0;
      ctlN.ovf  = 1'b0;
      irqN      = 1'b0;
    end
    if (stb.bufWr) begin
      bufN      = wdata;
      ctrN      = wdata;
      ctlN.done = 1'b0;
      ctlN.ovf  = 1'b0;
      irqN      = 1'b0;
    end
    if (stb.csrRd) begin
      ctlN.done = 1'b0;
      ctlN.ovf  = 1'b0;
      irqN      = 1'b0;
    end

    stepped = ctlN.up ? ctrN + DATA_W'(1) : ctrN - DATA_W'(1);
    if (tickNow) begin
      if (stepped == '0) begin
        if (ctlN.done) ctlN.ovf = 1'b1;
        else           ctlN.done = 1'b1;
        if (ctlN.ie) irqN = 1'b1;
        if (ctlN.rep) begin
          ctrN = bufN;
        end else begin
          ctrN     = '0;
          bufN     = '0;
          ctlN.run = 1'b0;
        end
      end else begin
        ctrN = stepped;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0;
      ctrQ <= '0;
      bufQ <= '0;
      irqQ <= 1'b0;
    end else begin
      ctlQ <= ctlN;
      ctrQ <= ctrN;
      bufQ <= bufN;
      irqQ <= irqN;
    end
  end

  always_comb begin
    csrView                         = '0;
    csrView[BIT_RUN]                = ctlQ.run;
    csrView[BIT_RATE_H:BIT_RATE_L]  = ctlQ.rate;
    csrView[BIT_REP]                = ctlQ.rep;
    csrView[BIT_UP]                 = ctlQ.up;
    csrView[BIT_IE]                 = ctlQ.ie;
    csrView[BIT_DONE]               = ctlQ.done;
    csrView[BIT_OVF]                = ctlQ.ovf;
  end

  always_comb begin
    rdata = '0;
    if (stb.rdEn) begin
      unique case (stb.rdSel)
        SLOT_CSR: rdata = DATA_W'(csrView);
        SLOT_CTR: rdata = ctrQ;
        default:  rdata = '0;
      endcase
    end
  end

  assign csrRun  = ctlQ.run;
  assign csrRate = ctlQ.rate;
  assign csrDone = ctlQ.done;
  assign csrOvf  = ctlQ.ovf;
  assign irq     = irqQ;

endmodule

// File: rtl/prog_interval_clock.sv
module prog_interval_clock
  import pic_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busByte,
  output logic [DATA_W-1:0] busRdata,
  input  logic [3:0]        rateTick,
  output logic              irq
);

  localparam int NUM_SRC = 1 << RATE_W;

  picStrobes_t stb;
  logic csrRun, csrDone, csrOvf;
  logic [RATE_W-1:0] csrRate;
  logic [DATA_W-1:0] ctrQ, bufQ;

  pic_ctrl #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .busByte (busByte),
    .wdRun   (busWdata[BIT_RUN]),
    .wdStep  (busWdata[BIT_STEP]),
    .rateTick(rateTick),
    .csrRun  (csrRun),
    .csrRate (csrRate),
    .stb     (stb)
  );

  pic_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .csrRun (csrRun),
    .csrRate(csrRate),
    .csrDone(csrDone),
    .csrOvf (csrOvf),
    .ctrQ   (ctrQ),
    .bufQ   (bufQ),
    .irq    (irq)
  );

endmodule

// File: rtl/prog_interval_clock_checker.sv
module prog_interval_clock_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic              busByte,
  input logic [DATA_W-1:0] busRdata,
  input logic              csrRun,
  input logic              csrDone,
  input logic              csrOvf,
  input logic [DATA_W-1:0] ctrQ,
  input logic [DATA_W-1:0] bufQ,
  input logic              irq
);

  logic wordOk, clearAcc, csrRdAcc, bufRdAcc, ctrWrAcc;
  assign wordOk   = !busByte && !busAddr[0];
  assign csrRdAcc = wordOk && busRd && (busAddr[2:1] == 2'd0);
  assign bufRdAcc = wordOk && busRd && (busAddr[2:1] == 2'd1);
  assign ctrWrAcc = wordOk && busWr && (busAddr[2:1] == 2'd2);
  assign clearAcc = csrRdAcc ||
                    (wordOk && busWr && (busAddr[2:1] == 2'd0 || busAddr[2:1] == 2'd1));

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(clearAcc)); // R8

  AST_OVF_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csrOvf) |-> $past(csrDone)); // R8

  AST_CTR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrWrAcc && !csrRun) |=> $stable(ctrQ)); // R5

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!csrRun && !busWr) |=> $stable(ctrQ)); // R6

  AST_CSR_READ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    csrRdAcc |-> (busRdata[14:8] == '0 && busRdata[5] == 1'b0)); // R2

  AST_BUF_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    bufRdAcc |-> (busRdata == '0)); // R2

  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csrRun) && !$past(busWr)) |-> (bufQ == '0 && ctrQ == '0)); // R9

endmodule

bind prog_interval_clock prog_interval_clock_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busRd   (busRd),
  .busWr   (busWr),
  .busByte (busByte),
  .busRdata(busRdata),
  .csrRun  (csrRun),
  .csrDone (csrDone),
  .csrOvf  (csrOvf),
  .ctrQ    (ctrQ),
  .bufQ    (bufQ),
  .irq     (irq)
);

// File: tb/prog_interval_clock_test.sv
module prog_interval_clock_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        busRd = 1'b0, busWr = 1'b0, busByte = 1'b0;
  logic [15:0] busRdata;
  logic [3:0]  rateTick = '0;
  logic        irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // reference state
  logic [15:0] mCsr, mCtr, mBuf;
  logic        mIrq;

  prog_interval_clock uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busRd(busRd), .busWr(busWr), .busByte(busByte), .busRdata(busRdata),
    .rateTick(rateTick), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [2:0] a, input logic byt);
    if (byt || a[0]) return 16'h0;
    case (a[2:1])
      2'd0: return mCsr & 16'h80FF;
      2'd2: return mCtr;
      default: return 16'h0;
    endcase
  endfunction

  task automatic modelStep(input logic [2:0] a, input logic [15:0] wd, input logic rd,
                           input logic wr, input logic byt, input logic [3:0] tk);
    logic ok, csrWr, bufWr, csrRd, tick;
    logic [15:0] nxt;
    ok    = !byt && !a[0];
    csrWr = ok && wr && a[2:1] == 2'd0;
    bufWr = ok && wr && a[2:1] == 2'd1;
    csrRd = ok && rd && a[2:1] == 2'd0;
    tick  = 1'b0;
    if (csrWr) begin
      mCsr = wd & 16'h005F;
      mIrq = 1'b0;
      tick = !wd[0] && wd[5];
    end else if (bufWr) begin
      mBuf = wd; mCtr = wd;
      mCsr[7] = 1'b0; mCsr[15] = 1'b0; mIrq = 1'b0;
    end else if (mCsr[0] && tk[mCsr[2:1]]) begin
      tick = 1'b1;
    end
    if (csrRd) begin
      mCsr[7] = 1'b0; mCsr[15] = 1'b0; mIrq = 1'b0;
    end
    if (tick) begin
      nxt = mCsr[4] ? mCtr + 16'd1 : mCtr - 16'd1;
      if (nxt == 16'h0) begin
        if (mCsr[7]) mCsr[15] = 1'b1; else mCsr[7] = 1'b1;
        if (mCsr[6]) mIrq = 1'b1;
        if (mCsr[3]) mCtr = mBuf;
        else begin mCtr = 16'h0; mBuf = 16'h0; mCsr[0] = 1'b0; end
      end else mCtr = nxt;
    end
  endtask

  // one bus cycle: drive at negedge, check read before the edge, irq after it
  task automatic cyc(input string tag, input logic [2:0] a, input logic [15:0] wd,
                     input logic rd, input logic wr, input logic byt, input logic [3:0] tk);
    @(negedge clk);
    busAddr = a; busWdata = wd; busRd = rd; busWr = wr; busByte = byt; rateTick = tk;
    #1;
    if (rd) check(tag, busRdata, expRead(a, byt));
    @(posedge clk);
    modelStep(a, wd, rd, wr, byt, tk);
    #1;
    check({tag, " irq"}, {15'h0, irq}, {15'h0, mIrq});
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0; busByte = 1'b0; rateTick = '0;
  endtask

  task automatic rdReg(input string tag, input logic [2:0] a);
    cyc(tag, a, 16'h0, 1'b1, 1'b0, 1'b0, 4'h0);
  endtask
  task automatic wrReg(input string tag, input logic [2:0] a, input logic [15:0] d);
    cyc(tag, a, d, 1'b0, 1'b1, 1'b0, 4'h0);
  endtask
  task automatic tickN(input string tag, input logic [3:0] tk, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 3'd0, 16'h0, 1'b0, 1'b0, 1'b0, tk);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int op;
    void'($urandom(32'd2024));
    mCsr = 0; mCtr = 0; mBuf = 0; mIrq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rdReg("R1 csr", 3'd0);
    rdReg("R1 ctr", 3'd4);
    rdReg("R2 buf reads zero", 3'd2);
    rdReg("R2 empty slot", 3'd6);

    // R4 buffer load, R5 ignored accesses
    wrReg("R4 buf write", 3'd2, 16'd3);
    rdReg("R4 ctr loaded", 3'd4);
    wrReg("R5 ctr write", 3'd4, 16'h1234);
    rdReg("R5 ctr after ctr write", 3'd4);
    cyc("R5 byte write", 3'd2, 16'h0055, 1'b0, 1'b1, 1'b1, 4'h0);
    cyc("R5 odd write", 3'd3, 16'h0077, 1'b0, 1'b1, 1'b0, 4'h0);
    cyc("R5 odd read", 3'd5, 16'h0, 1'b1, 1'b0, 1'b0, 4'h0);
    rdReg("R5 ctr after byte/odd", 3'd4);

    // R3/R6/R8/R9 single mode down, slow crystal, interrupts on
    wrReg("R3 csr write", 3'd0, 16'hFFC3 & ~16'h0038);
    tickN("R6 unselected sources", 4'b1101, 4);
    rdReg("R6 ctr unchanged", 3'd4);
    tickN("R8 slow ticks", 4'b0010, 3);
    rdReg("R9 single stopped ctr", 3'd4);
    rdReg("R8 R9 csr done run clear", 3'd0);
    rdReg("R10 csr after clear", 3'd0);

    // R7 wrap up, R9 reload, R8 overrun
    wrReg("R4 buf FFFE", 3'd2, 16'hFFFE);
    wrReg("R3 repeat up", 3'd0, 16'h0059);
    tickN("R7 up ticks", 4'b0001, 2);
    rdReg("R9 reload value", 3'd4);
    tickN("R8 second terminal", 4'b0001, 2);
    rdReg("R8 overrun set", 3'd0);

    // R11 manual tick while stopped
    wrReg("R4 buf 1", 3'd2, 16'd1);
    wrReg("R11 manual tick", 3'd0, 16'h0060);
    rdReg("R11 csr done bit5 zero", 3'd0);
    rdReg("R11 ctr", 3'd4);
    wrReg("R11 manual up", 3'd0, 16'h0030);
    rdReg("R11 ctr up", 3'd4);

    // R12 write wins over tick
    wrReg("R4 buf 5", 3'd2, 16'd5);
    wrReg("R3 run fast", 3'd0, 16'h0041);
    cyc("R12 buf write with tick", 3'd2, 16'd9, 1'b0, 1'b1, 1'b0, 4'hF);
    rdReg("R12 ctr", 3'd4);

    // R10 read same cycle as terminal
    wrReg("R4 buf 1", 3'd2, 16'd1);
    wrReg("R3 repeat fast", 3'd0, 16'h0049);
    tickN("R8 term", 4'h1, 1);
    cyc("R10 read with terminal", 3'd0, 16'h0, 1'b1, 1'b0, 1'b0, 4'h1);
    rdReg("R10 csr after", 3'd0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      op = int'($urandom % 10);
      w = 16'($urandom);
      case (op)
        0, 1: rdReg("R2 rand read", 3'($urandom % 8));
        2: wrReg("R3 rand csr", 3'd0, (w & 16'hFFFE) | 16'(($urandom % 4) != 0));
        3: wrReg("R4 rand buf", 3'd2, ($urandom % 2) ? 16'($urandom % 4) : 16'hFFFF - 16'($urandom % 3));
        4: cyc("R5 rand bad", 3'($urandom % 8), w, 1'b0, 1'b1, 1'b1, 4'($urandom));
        5: cyc("R10 rand read tick", 3'd0, 16'h0, 1'b1, 1'b0, 1'b0, 4'($urandom));
        default: cyc("R7 rand tick", 3'd0, 16'h0, 1'b0, 1'b0, 1'b0, 4'($urandom));
      endcase
      if (i % 50 == 0) rdReg("R7 rand ctr", 3'd4);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule